// File: doc/BRIEF.md
# Vector Compare-and-Mask Unit

This unit runs one vector instruction at a time over a stream of signed integer elements. A compare instruction evaluates one of six relations, either between two vector operands or between a vector operand and a scalar that is applied to every element. The result for each element is written as one bit into a persistent mask register. A later masked subtract instruction steps through the same element positions. It issues a write of `a - b` to an external destination register array only where the mask bit is 1.

A `start` pulse launches an instruction, and the operation code, relation, vector length and scalar are captured on the accepting edge. While `busy` is high, the unit presents the index of the element it consumes on the next edge, and the surrounding datapath supplies that element's operands. Each element takes exactly one cycle whether or not its result is kept. `done` pulses once when the instruction ends. After reset the mask holds all ones, so a subtract issued before any compare writes every element.

Top module: `vmask_unit`

## Requirements
- R1: While `rst` is held and just after it is released, `mask` is all ones, and `busy`, `done` and `wr_en` are 0.
- R2: The relation code selects a signed comparison of the first operand `a` against the second operand `b`: 0 equal, 1 not equal, 2 a>b, 3 a<b, 4 a>=b, 5 a<=b. Codes 6 and 7 are never true.
- R3: With `op`=0 the second operand is `in_b` of the same element. With `op`=1 it is the `scalar` captured at start, and `in_b` has no effect.
- R4: For each element position i below VL, a compare writes mask bit i as 1 when the relation holds and as 0 when it does not.
- R5: After a compare, every mask bit at a position at or above VL is 0. A compare with VL=0 clears the whole mask.
- R6: An instruction consumes elements 0 to VL-1 in order, one per cycle, with `elem_idx` showing the current position. `done` is high for one cycle, after the (VL+1)th rising edge counted from and including the edge that accepts `start`. VL never exceeds 64.
- R7: With `op`=2, element i (i below VL) produces a write with `wr_idx`=i and `wr_data`=`in_a`-`in_b`, wrapped to 16 bits, exactly when mask bit i is 1. The mask is left unchanged.
- R8: A masked subtract issued after reset and before any compare writes every element position below VL.
- R9: A `start` that arrives while `busy` is high is ignored. The running instruction completes with its own settings, and no second instruction follows.
- R10: `op`=3 steps through VL elements with the same timing but makes no writes and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, accepted when idle |
| op | input | 2 | 0 compare vector/vector, 1 compare vector/scalar, 2 masked subtract, 3 step only |
| rel | input | 3 | Relation code for compares |
| vlen | input | 7 | Active vector length, 0 to 64 |
| scalar | input | 16 | Scalar second operand for the vector/scalar compare |
| in_a | input | 16 | First operand of the element at `elem_idx` |
| in_b | input | 16 | Second operand of the element at `elem_idx` |
| busy | output | 1 | Instruction in progress |
| elem_idx | output | 6 | Element consumed at the next rising edge |
| done | output | 1 | One-cycle completion pulse |
| mask | output | 64 | Mask register, bit i belongs to element i |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 6 | Destination element position |
| wr_data | output | 16 | Difference to be written |

## Verification
The assertions take it for granted that `vlen` never exceeds 64 when a start is accepted, and this assumption is checked as a property of its own. They also assume that the operands on `in_a` and `in_b` during a busy cycle belong to the element shown on `elem_idx`. The stimulus keeps within both assumptions. Every launch uses lengths from 0 to 64. On each falling edge the bench looks up the operands of the reported index in its own arrays and drives them. A start raised during a busy instruction deliberately carries different settings, so that any leak of those settings would show in the mask or the timing.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  typedef enum logic [1:0] {
    OP_CMP_VV     = 2'd0,
    OP_CMP_VS     = 2'd1,
    OP_SUB_MASKED = 2'd2,
    OP_STEP_ONLY  = 2'd3
  } vop_e;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_GT = 3'd2,
    REL_LT = 3'd3,
    REL_GE = 3'd4,
    REL_LE = 3'd5
  } vrel_e;
endpackage

// File: rtl/vcm_relation.sv
module vcm_relation #(
  parameter int W = 16
) (
  input  logic [2:0]         rel,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic               hit
);
  import vcm_pkg::*;

  always_comb begin
    case (rel)
      REL_EQ:  hit = (a == b);
      REL_NE:  hit = (a != b);
      REL_GT:  hit = (a > b);
      REL_LT:  hit = (a < b);
      REL_GE:  hit = (a >= b);
      REL_LE:  hit = (a <= b);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcm_sequencer.sv
module vcm_sequencer #(
  parameter int MVL = 64,
  localparam int IW  = (MVL > 1) ? $clog2(MVL) : 1,
  localparam int VLW = $clog2(MVL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [VLW-1:0] vlen,
  output logic           accept,
  output logic           busy,
  output logic [IW-1:0]  idx,
  output logic [VLW-1:0] vl_q,
  output logic           done
);
  logic last;

  assign accept = start && !busy;
  assign last   = busy && ((VLW'(idx) + VLW'(1)) == vl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      vl_q <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        vl_q <= vlen;
        idx  <= '0;
        busy <= (vlen != '0);
        done <= (vlen == '0);
      end else if (busy) begin
        idx <= idx + IW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_VL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    accept |-> (vlen <= VLW'(MVL))) else $error("vlen above MVL"); // R6
  AST_IDX_BELOW_VL: assert property (@(posedge clk) disable iff (rst)
    busy |-> (VLW'(idx) < vl_q)) else $error("element index beyond VL"); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy"); // R6
endmodule

// File: rtl/vcm_mask_reg.sv
module vcm_mask_reg #(
  parameter int MVL = 64,
  localparam int IW = (MVL > 1) ? $clog2(MVL) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           bit_we,
  input  logic [IW-1:0]  bit_pos,
  input  logic           bit_val,
  output logic [MVL-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)         mask <= '1;
    else if (clr)    mask <= '0;
    else if (bit_we) mask[bit_pos] <= bit_val;
  end

  AST_CLR_NOT_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    clr |-> !bit_we) else $error("clear collides with bit write"); // R5
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit #(
  parameter int W   = 16,
  parameter int MVL = 64,
  localparam int IW  = (MVL > 1) ? $clog2(MVL) : 1,
  localparam int VLW = $clog2(MVL + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [2:0]          rel,
  input  logic [VLW-1:0]      vlen,
  input  logic signed [W-1:0] scalar,
  input  logic signed [W-1:0] in_a,
  input  logic signed [W-1:0] in_b,
  output logic                busy,
  output logic [IW-1:0]       elem_idx,
  output logic                done,
  output logic [MVL-1:0]      mask,
  output logic                wr_en,
  output logic [IW-1:0]       wr_idx,
  output logic [W-1:0]        wr_data
);
  import vcm_pkg::*;

  logic            accept;
  logic [VLW-1:0]  vl_q;
  vop_e            op_q;
  logic [2:0]      rel_q;
  logic [W-1:0]    scalar_q;
  logic            is_cmp_q;
  logic            is_sub_q;
  logic signed [W-1:0] rhs;
  logic            hit;

  vcm_sequencer #(.MVL(MVL)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .vlen   (vlen),
    .accept (accept),
    .busy   (busy),
    .idx    (elem_idx),
    .vl_q   (vl_q),
    .done   (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_STEP_ONLY;
      rel_q    <= '0;
      scalar_q <= '0;
    end else if (accept) begin
      op_q     <= vop_e'(op);
      rel_q    <= rel;
      scalar_q <= scalar;
    end
  end

  assign is_cmp_q = (op_q == OP_CMP_VV) || (op_q == OP_CMP_VS);
  assign is_sub_q = (op_q == OP_SUB_MASKED);
  assign rhs      = (op_q == OP_CMP_VS) ? signed'(scalar_q) : in_b;

  vcm_relation #(.W(W)) u_rel (
    .rel (rel_q),
    .a   (in_a),
    .b   (rhs),
    .hit (hit)
  );

  vcm_mask_reg #(.MVL(MVL)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept && (vop_e'(op) == OP_CMP_VV || vop_e'(op) == OP_CMP_VS)),
    .bit_we  (busy && is_cmp_q),
    .bit_pos (elem_idx),
    .bit_val (hit),
    .mask    (mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= busy && is_sub_q && mask[elem_idx];
      if (busy && is_sub_q) begin
        wr_idx  <= elem_idx;
        wr_data <= in_a - in_b;
      end
    end
  end

  AST_WR_ONLY_MASKED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> mask[wr_idx]) else $error("write at masked-off position"); // R7
  AST_NO_WR_OUTSIDE_SUB: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_sub_q) |=> !wr_en) else $error("write from non-subtract op"); // R10
  AST_MASK_HELD_NON_CMP: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_cmp_q) |=> $stable(mask)) else $error("mask moved outside compare"); // R7
  AST_HIGH_BITS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (done && is_cmp_q) |-> ((mask >> vl_q) == '0)) else $error("mask bit above VL set"); // R5
endmodule

// File: tb/tb_vmask_unit.sv
module tb_vmask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MVL = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [2:0]  rel = '0;
  logic [6:0]  vlen = '0;
  logic signed [15:0] scalar = '0;
  logic signed [15:0] in_a = '0;
  logic signed [15:0] in_b = '0;
  logic        busy, done, wr_en;
  logic [5:0]  elem_idx, wr_idx;
  logic [63:0] mask;
  logic [15:0] wr_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic signed [15:0] A [MVL];
  logic signed [15:0] B [MVL];
  logic [15:0] dst [MVL];
  bit          wrote [MVL];
  int          idx_err;

  vmask_unit dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .rel(rel), .vlen(vlen),
    .scalar(scalar), .in_a(in_a), .in_b(in_b), .busy(busy), .elem_idx(elem_idx),
    .done(done), .mask(mask), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic rel_ok(input logic [2:0] r, input logic signed [15:0] a, input logic signed [15:0] b);
    case (r)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return a > b;
      3'd3: return a < b;
      3'd4: return a >= b;
      3'd5: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] exp_mask(input bit vs, input logic [2:0] r, input int vl, input logic signed [15:0] s);
    logic [63:0] m = '0;
    for (int i = 0; i < vl; i++) m[i] = rel_ok(r, A[i], vs ? s : B[i]);
    return m;
  endfunction

  // Launch one instruction and follow it to done; poke_at > 0 raises a second start mid-run.
  task automatic run_op(input logic [1:0] o, input logic [2:0] r, input int vl,
                        input logic signed [15:0] s, input int poke_at, output int cyc);
    int expi = 0;
    for (int i = 0; i < MVL; i++) begin wrote[i] = 0; dst[i] = '0; end
    idx_err = 0;
    @(negedge clk);
    start = 1'b1; op = o; rel = r; vlen = 7'(vl); scalar = s;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (poke_at > 0 && cyc == poke_at) begin
        start = 1'b1; op = 2'd3; vlen = 7'd5; scalar = 16'sd0; rel = 3'd1;
      end else start = 1'b0;
      if (wr_en) begin wrote[wr_idx] = 1; dst[wr_idx] = wr_data; end
      if (busy) begin
        if (int'(elem_idx) != expi) idx_err++;
        expi++;
        in_a = A[elem_idx];
        in_b = B[elem_idx];
      end
    end while (!done && cyc < 300);
    start = 1'b0;
  endtask

  task automatic test_reset();
    check(mask == '1, "R1 mask after reset", mask, '1);
    check(!busy && !done && !wr_en, "R1 idle outputs after reset", {busy, done, wr_en}, 0);
  endtask

  task automatic test_sub_after_reset();
    int cyc, bad = 0;
    run_op(2'd2, 3'd0, 10, 16'sd0, 0, cyc);
    for (int i = 0; i < 10; i++)
      if (!wrote[i] || dst[i] != 16'(A[i] - B[i])) bad++;
    check(bad == 0, "R8 unmasked subtract writes all", bad, 0);
    check(dst[0] == 16'h0001, "R7 wrap of -32768-32767", dst[0], 16'h0001);
    check(cyc == 11, "R6 subtract cycle count", cyc, 11);
  endtask

  task automatic test_vv_relations();
    int cyc;
    for (int r = 0; r < 8; r++) begin
      logic [63:0] e;
      run_op(2'd0, 3'(r), 20, 16'sd0, 0, cyc);
      e = exp_mask(0, 3'(r), 20, 16'sd0);
      check(mask == e, $sformatf("R2 R4 vector compare rel %0d", r), mask, e);
    end
    check((mask >> 20) == 0, "R5 high bits zero after compare", mask, 0);
  endtask

  task automatic test_vs_full();
    int cyc;
    logic [63:0] e;
    run_op(2'd1, 3'd4, 64, 16'sd1, 0, cyc);
    e = exp_mask(1, 3'd4, 64, 16'sd1);
    check(mask == e, "R3 scalar compare uses scalar, ignores in_b", mask, e);
    check(cyc == 65, "R6 full length cycle count", cyc, 65);
    check(idx_err == 0, "R6 element order", idx_err, 0);
  endtask

  task automatic test_vl_zero();
    int cyc;
    run_op(2'd0, 3'd1, 12, 16'sd0, 0, cyc);
    run_op(2'd0, 3'd1, 0, 16'sd0, 0, cyc);
    check(mask == '0, "R5 VL=0 compare clears mask", mask, 0);
    check(cyc == 1, "R6 VL=0 done timing", cyc, 1);
  endtask

  task automatic test_masked_sub();
    int cyc, bad = 0;
    logic [63:0] m, e;
    run_op(2'd1, 3'd2, 30, 16'sd0, 0, cyc);
    e = exp_mask(1, 3'd2, 30, 16'sd0);
    check(mask == e, "R4 greater-than-scalar mask", mask, e);
    m = mask;
    run_op(2'd2, 3'd0, 40, 16'sd0, 0, cyc);
    for (int i = 0; i < MVL; i++) begin
      if (wrote[i] != ((i < 40) && m[i])) bad++;
      if (wrote[i] && dst[i] != 16'(A[i] - B[i])) bad++;
    end
    check(bad == 0, "R7 writes only at set mask bits", bad, 0);
    check(mask == m, "R7 mask unchanged by subtract", mask, m);
    check(cyc == 41, "R7 masked elements still take a cycle", cyc, 41);
  endtask

  task automatic test_busy_start();
    int cyc;
    logic [63:0] e;
    run_op(2'd0, 3'd3, 12, 16'sd0, 3, cyc);
    e = exp_mask(0, 3'd3, 12, 16'sd0);
    check(mask == e, "R9 mask from first instruction only", mask, e);
    check(cyc == 13, "R9 timing unaffected", cyc, 13);
    @(negedge clk);
    check(!busy && !done, "R9 no second instruction", {busy, done}, 0);
  endtask

  task automatic test_step_only();
    int cyc, nw = 0;
    logic [63:0] m;
    m = mask;
    run_op(2'd3, 3'd0, 8, 16'sd0, 0, cyc);
    for (int i = 0; i < MVL; i++) if (wrote[i]) nw++;
    check(nw == 0, "R10 step-only makes no writes", nw, 0);
    check(mask == m, "R10 step-only keeps mask", mask, m);
    check(cyc == 9, "R10 step-only timing", cyc, 9);
  endtask

  initial begin
    for (int i = 0; i < MVL; i++) begin
      A[i] = 16'((i * 7) % 9 - 4);
      B[i] = 16'((i * 5) % 7 - 3);
    end
    A[0] = -16'sd32768; B[0] = 16'sd32767;
    A[1] = 16'sd32767;  B[1] = -16'sd32768;
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_sub_after_reset();
    test_vv_relations();
    test_vs_full();
    test_vl_zero();
    test_masked_sub();
    test_busy_start();
    test_step_only();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule